// File: doc/BRIEF.md
# Multi-Profile Rise/Fall PWM Generator

This block drives a set of PWM lines, typically fan drives. Each output is high over a window of a repeating step count. The window opens at a programmable rise step and closes at a programmable fall step. The step counters are not per port. The block has a small number of shared timing profiles. Each profile has its own prescaler and its own period counter, and each port picks one profile with a type code. Many ports can then share a few timing settings while keeping their own duty windows.

A profile's prescaler divides the input clock by a linear factor times a power of two. The period counter then steps from 0 up to the programmed period value, so the output repeats every (linear × 2^exponent × (period + 1)) clocks. The rise and fall settings for a pair of ports arrive packed in one 32-bit word. A new window is copied into the port's working copy only when the selected profile wraps, so a change in the middle of a period never cuts a pulse short or stretches it. A global enable runs or stops all the profiles together.

Top module: `pwm_rf_gen`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it, every bit of `pwm_out` is 0.
- R2: A profile with exponent E, linear value L and period P repeats every D×(P+1) clocks, where D = max(L,1)×2^E. Its step counter advances once every D clocks and returns to 0 after step P.
- R3: Step c of the selected profile drives the port high when c ≥ rise and (fall = 0 or c < fall). If rise ≥ fall and fall is not 0, the port stays low.
- R4: A rise of 0 together with a fall of 0 keeps an enabled port high for the whole period.
- R5: Duty word k holds two ports. Port 2k takes rise from bits 7:0 and fall from bits 15:8. Port 2k+1 takes rise from bits 23:16 and fall from bits 31:24.
- R6: Type code 0, 1 or 2 selects profile 0, 1 or 2. Code 3 selects no profile, and the port then drives 0.
- R7: Clearing a port's enable drives that port to 0 on the next clock. Setting the enable again restores the output on the next clock.
- R8: On an enabled, running port, a changed rise or fall value first applies at step 0 after the selected profile wraps. The steps left in the current period keep the old window.
- R9: While `clk_en` is low, all outputs are 0 and all step counters are held at 0. After `clk_en` rises, the first output sample reflects step 0.
- R10: A linear value of 0 divides the same as a linear value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Global run enable for all profiles |
| prof_exp | input | N_PROF*EXP_W | Power-of-two exponent for each profile |
| prof_lin | input | N_PROF*LIN_W | Linear divide factor for each profile (0 counts as 1) |
| prof_period | input | N_PROF*STEP_W | Last step value of each profile's period |
| port_en | input | N_PORTS | Enable for each port |
| port_type | input | N_PORTS*SEL_W | Profile select for each port (3 means none) |
| duty_word | input | (N_PORTS/2)*4*STEP_W | Packed rise and fall steps, two ports per word |
| pwm_out | output | N_PORTS | PWM output lines |

## Verification
A step counter that is off shows up on the ports within one period, as a wrong count of high samples or of rising edges in a window of whole periods. High-time counts are taken over whole periods, so they do not depend on phase and expose a wrong prescale factor, a wrong compare rule or crossed duty fields. A working copy that loads at the wrong time shows up within the same period: high samples appear before the wrap, or the old window is still present after it. Enable and type-code faults show up one clock after the input changes.

// File: rtl/pwm_rf_pkg.sv
package pwm_rf_pkg;

  // Profile select codes; any code at or above the profile count means none.
  typedef enum logic [1:0] {
    SEL_PROF0 = 2'd0,
    SEL_PROF1 = 2'd1,
    SEL_PROF2 = 2'd2,
    SEL_NONE  = 2'd3
  } prof_sel_e;

  // Total clock division of the prescaler: linear factor (0 -> 1) times 2^expo.
  function automatic int unsigned div_factor(input int unsigned lin,
                                             input int unsigned expo);
    int unsigned l_eff;
    l_eff = (lin == 0) ? 1 : lin;
    return l_eff << expo;
  endfunction

  // Window rule: open at rise, close at fall; fall of 0 means end of period.
  function automatic logic step_is_high(input int unsigned step,
                                        input int unsigned rise,
                                        input int unsigned fall);
    return (step >= rise) && ((fall == 0) || (step < fall));
  endfunction

endpackage

// File: rtl/pwm_rf_timebase.sv
module pwm_rf_timebase #(
  parameter int STEP_W = 8,
  parameter int EXP_W  = 3,
  parameter int LIN_W  = 4,
  parameter int PRE_W  = LIN_W + (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [EXP_W-1:0]  div_exp,
  input  logic [LIN_W-1:0]  div_lin,
  input  logic [STEP_W-1:0] period,
  output logic [STEP_W-1:0] step,
  output logic              tick,
  output logic              wrap
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_limit;

  assign pre_limit = PRE_W'(pwm_rf_pkg::div_factor(32'(div_lin), 32'(div_exp)) - 32'd1);
  // >= keeps the counters bounded when settings shrink mid-period
  assign tick = run && (pre_cnt >= pre_limit);
  assign wrap = tick && (step >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      step    <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      step    <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      step    <= wrap ? '0 : step + STEP_W'(1);
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/pwm_rf_channel.sv
module pwm_rf_channel #(
  parameter int N_PROF = 3,
  parameter int STEP_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     en,
  input  logic [SEL_W-1:0]         sel,
  input  logic [STEP_W-1:0]        rise,
  input  logic [STEP_W-1:0]        fall,
  input  logic [N_PROF*STEP_W-1:0] steps,
  input  logic [N_PROF-1:0]        wraps,
  output logic                     pwm
);
  logic [STEP_W-1:0] step_sel;
  logic              wrap_sel;
  logic              sel_valid;
  logic              load;
  logic              level;
  logic [STEP_W-1:0] rise_sh;
  logic [STEP_W-1:0] fall_sh;

  assign sel_valid = (32'(sel) < N_PROF);

  always_comb begin
    step_sel = '0;
    wrap_sel = 1'b0;
    for (int g = 0; g < N_PROF; g++) begin
      if (32'(sel) == g) begin
        step_sel = steps[g*STEP_W +: STEP_W];
        wrap_sel = wraps[g];
      end
    end
  end

  // Working copy follows the inputs while idle, else only at a period wrap.
  assign load  = !run || !en || !sel_valid || wrap_sel;
  assign level = pwm_rf_pkg::step_is_high(32'(step_sel), 32'(rise_sh), 32'(fall_sh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_sh <= '0;
      fall_sh <= '0;
      pwm     <= 1'b0;
    end else begin
      if (load) begin
        rise_sh <= rise;
        fall_sh <= fall;
      end
      pwm <= run && en && sel_valid && level;
    end
  end
endmodule

// File: rtl/pwm_rf_gen.sv
module pwm_rf_gen #(
  parameter int N_PORTS = 4,
  parameter int N_PROF  = 3,
  parameter int STEP_W  = 8,
  parameter int EXP_W   = 3,
  parameter int LIN_W   = 4,
  parameter int SEL_W   = $clog2(N_PROF + 1),
  parameter int WORD_W  = 4 * STEP_W,
  parameter int N_WORDS = N_PORTS / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en,
  input  logic [N_PROF*EXP_W-1:0]   prof_exp,
  input  logic [N_PROF*LIN_W-1:0]   prof_lin,
  input  logic [N_PROF*STEP_W-1:0]  prof_period,
  input  logic [N_PORTS-1:0]        port_en,
  input  logic [N_PORTS*SEL_W-1:0]  port_type,
  input  logic [N_WORDS*WORD_W-1:0] duty_word,
  output logic [N_PORTS-1:0]        pwm_out
);
  localparam int PRE_W = LIN_W + (1 << EXP_W) - 1;

  // Named internal events, observed by the bound checker.
  logic [N_PROF*STEP_W-1:0] prof_step_w;
  logic [N_PROF-1:0]        prof_tick_w;
  logic [N_PROF-1:0]        prof_wrap_w;

  for (genvar g = 0; g < N_PROF; g++) begin : g_prof
    pwm_rf_timebase #(
      .STEP_W(STEP_W), .EXP_W(EXP_W), .LIN_W(LIN_W), .PRE_W(PRE_W)
    ) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (clk_en),
      .div_exp (prof_exp[g*EXP_W +: EXP_W]),
      .div_lin (prof_lin[g*LIN_W +: LIN_W]),
      .period  (prof_period[g*STEP_W +: STEP_W]),
      .step    (prof_step_w[g*STEP_W +: STEP_W]),
      .tick    (prof_tick_w[g]),
      .wrap    (prof_wrap_w[g])
    );
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    // even port: low half of the word, odd port: high half (rise below fall)
    localparam int BASE = (p / 2) * WORD_W + (p % 2) * 2 * STEP_W;
    pwm_rf_channel #(
      .N_PROF(N_PROF), .STEP_W(STEP_W), .SEL_W(SEL_W)
    ) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (clk_en),
      .en    (port_en[p]),
      .sel   (port_type[p*SEL_W +: SEL_W]),
      .rise  (duty_word[BASE +: STEP_W]),
      .fall  (duty_word[BASE + STEP_W +: STEP_W]),
      .steps (prof_step_w),
      .wraps (prof_wrap_w),
      .pwm   (pwm_out[p])
    );
  end
endmodule

// File: rtl/pwm_rf_gen_chk.sv
module pwm_rf_gen_chk #(
  parameter int N_PORTS = 4,
  parameter int N_PROF  = 3,
  parameter int STEP_W  = 8,
  parameter int SEL_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clk_en,
  input logic [N_PORTS-1:0]       port_en,
  input logic [N_PORTS*SEL_W-1:0] port_type,
  input logic [N_PORTS-1:0]       pwm_out,
  input logic [N_PROF*STEP_W-1:0] prof_step_w,
  input logic [N_PROF-1:0]        prof_tick_w,
  input logic [N_PROF-1:0]        prof_wrap_w
);
  p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> pwm_out == '0);

  p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> prof_step_w == '0);

  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> pwm_out == '0);

  for (genvar g = 0; g < N_PROF; g++) begin : g_pc
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      prof_wrap_w[g] |=> prof_step_w[g*STEP_W +: STEP_W] == '0);
    p_step_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && prof_tick_w[g] && !prof_wrap_w[g] |=>
        prof_step_w[g*STEP_W +: STEP_W] == $past(prof_step_w[g*STEP_W +: STEP_W]) + STEP_W'(1));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && !prof_tick_w[g] |=> $stable(prof_step_w[g*STEP_W +: STEP_W]));
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_pp
    p_dis_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en[p] |=> !pwm_out[p]);
    p_no_prof_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(port_type[p*SEL_W +: SEL_W]) >= N_PROF) |=> !pwm_out[p]);
  end
endmodule

bind pwm_rf_gen pwm_rf_gen_chk #(
  .N_PORTS(N_PORTS), .N_PROF(N_PROF), .STEP_W(STEP_W), .SEL_W(SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en      (clk_en),
  .port_en     (port_en),
  .port_type   (port_type),
  .pwm_out     (pwm_out),
  .prof_step_w (prof_step_w),
  .prof_tick_w (prof_tick_w),
  .prof_wrap_w (prof_wrap_w)
);

// File: tb/sim_pwm_rf_gen.sv
module sim_pwm_rf_gen;
  localparam int NP = 4, NF = 3, SW = 8, EW = 3, LW = 4, SELW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic [NF*EW-1:0]    prof_exp = '0;
  logic [NF*LW-1:0]    prof_lin = '0;
  logic [NF*SW-1:0]    prof_period = '0;
  logic [NP-1:0]       port_en = '0;
  logic [NP*SELW-1:0]  port_type = '0;
  logic [(NP/2)*32-1:0] duty_word = '0;
  logic [NP-1:0]       pwm_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pwm_rf_gen u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .prof_exp(prof_exp),
    .prof_lin(prof_lin), .prof_period(prof_period), .port_en(port_en),
    .port_type(port_type), .duty_word(duty_word), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_prof(input int g, input int e, input int l, input int per);
    prof_exp[g*EW +: EW]    = EW'(e);
    prof_lin[g*LW +: LW]    = LW'(l);
    prof_period[g*SW +: SW] = SW'(per);
  endtask

  // R5 packing: port 2k -> bits 7:0 rise, 15:8 fall; port 2k+1 -> 23:16, 31:24
  task automatic set_duty(input int p, input int r, input int f);
    duty_word[(p/2)*32 + (p%2)*16 +: 8]     = 8'(r);
    duty_word[(p/2)*32 + (p%2)*16 + 8 +: 8] = 8'(f);
  endtask

  task automatic set_port(input int p, input bit en, input int typ);
    port_en[p] = en;
    port_type[p*SELW +: SELW] = SELW'(typ);
  endtask

  task automatic measure(input int p, input int n, output int highs, output int rises);
    logic prev;
    prev = pwm_out[p];
    highs = 0;
    rises = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[p]) highs++;
      if (pwm_out[p] && !prev) rises++;
      prev = pwm_out[p];
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pwm_out == '0, "R1 outputs low in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == '0, "R1 outputs low after reset", int'(pwm_out), 0);
  endtask

  task automatic t_profiles;
    int h, r;
    set_prof(0, 0, 1, 9);   // D=1, 10 clocks
    set_prof(1, 1, 2, 3);   // D=4, 16 clocks
    set_prof(2, 2, 0, 4);   // lin 0 -> 1, D=4, 20 clocks (R10)
    set_duty(0, 0, 5);
    set_duty(1, 0, 1);
    set_duty(2, 2, 0);
    set_duty(3, 0, 0);
    set_port(0, 1'b1, 0);
    set_port(1, 1'b1, 1);
    set_port(2, 1'b1, 2);
    set_port(3, 1'b1, 3);
    clk_en = 1'b1;
    repeat (160) @(negedge clk);
    measure(0, 80, h, r);
    check(h == 40, "R3 port0 high count", h, 40);
    check(r == 8,  "R2 port0 period edges", r, 8);
    measure(1, 80, h, r);
    check(h == 20, "R5 odd port fields, R2 prescale highs", h, 20);
    check(r == 5,  "R2 port1 period edges", r, 5);
    measure(2, 80, h, r);
    check(h == 48, "R10 zero linear factor highs", h, 48);
    measure(3, 80, h, r);
    check(h == 0,  "R6 type code 3 drives low", h, 0);
  endtask

  task automatic t_windows;
    int h, r;
    set_duty(0, 0, 0);
    repeat (30) @(negedge clk);
    measure(0, 20, h, r);
    check(h == 20, "R4 rise0 fall0 constant high", h, 20);
    set_duty(0, 7, 3);
    repeat (30) @(negedge clk);
    measure(0, 20, h, r);
    check(h == 0, "R3 rise above fall stays low", h, 0);
  endtask

  task automatic t_boundary;
    int h, r, guard;
    set_duty(0, 0, 1);
    repeat (30) @(negedge clk);
    guard = 0;
    while (!pwm_out[0] && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check(pwm_out[0] == 1'b1, "R8 found step-0 pulse", int'(pwm_out[0]), 1);
    set_duty(0, 0, 0);      // change mid-period
    measure(0, 9, h, r);
    check(h == 0, "R8 old window kept until wrap", h, 0);
    measure(0, 10, h, r);
    check(h == 10, "R8 new window after wrap", h, 10);
  endtask

  task automatic t_disable;
    repeat (10) @(negedge clk);
    check(pwm_out[0] == 1'b1, "R7 enabled high before disable", int'(pwm_out[0]), 1);
    port_en[0] = 1'b0;
    @(negedge clk);
    check(pwm_out[0] == 1'b0, "R7 low one clock after disable", int'(pwm_out[0]), 0);
    port_en[0] = 1'b1;
    @(negedge clk);
    check(pwm_out[0] == 1'b1, "R7 restored one clock after enable", int'(pwm_out[0]), 1);
  endtask

  task automatic t_global;
    int h, r;
    clk_en = 1'b0;
    @(negedge clk);
    check(pwm_out == '0, "R9 all low when stopped", int'(pwm_out), 0);
    set_duty(0, 0, 1);
    repeat (5) @(negedge clk);
    check(pwm_out == '0, "R9 still low while stopped", int'(pwm_out), 0);
    clk_en = 1'b1;
    @(negedge clk);
    check(pwm_out[0] == 1'b1, "R9 restart shows step 0", int'(pwm_out[0]), 1);
    measure(0, 9, h, r);
    check(h == 0, "R9 steps 1..9 low after restart", h, 0);
    @(negedge clk);
    check(pwm_out[0] == 1'b1, "R9 next step 0 after restart", int'(pwm_out[0]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_profiles();
    t_windows();
    t_boundary();
    t_disable();
    t_global();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule